// File: doc/BRIEF.md
# Phase Detector with Sequenced Power Control

This block is the digital core of a charge-pump phase-locked loop. It watches two one-cycle strobes: one from the reference divider and one from the divided VCO. The strobe that arrives first opens a pump pulse. A reference-first arrival drives `pump_up`, which makes the pump source current. A VCO-first arrival drives `pump_dn`, which makes it sink current. When the other strobe arrives, both outputs stay high together for a short fixed window and then drop together. The leading pulse is therefore as long as the arrival gap plus that window. The window also keeps the detector gain linear when the phase error is very small.

A power request input controls the detector through a small sequencer with four states. The states are `PW_OFF`, `PW_SYNC`, `PW_RUN` and `PW_DRAIN`.
- In `PW_OFF` the detector is idle, and a high `pwr_on` moves it to `PW_SYNC`.
- In `PW_SYNC` the block raises `div_restart` for one cycle so that both dividers restart aligned. It then moves to `PW_RUN`, or back to `PW_OFF` if the request has already gone away.
- In `PW_RUN` new pulses may start.
- When the request falls in `PW_RUN` with no pulse open, the sequencer goes straight to `PW_OFF`. When a pulse is open, it goes to `PW_DRAIN` instead.
- `PW_DRAIN` lets the open pulse finish normally and then moves to `PW_OFF`.

The detector has its own four states, `PD_IDLE`, `PD_LEAD_UP`, `PD_LEAD_DN` and `PD_OVERLAP`. Their two-bit codes are the values of {up, dn}.
- From `PD_IDLE`, a reference strobe enters `PD_LEAD_UP` and a VCO strobe enters `PD_LEAD_DN`. Both strobes in the same cycle enter `PD_OVERLAP` directly.
- From a lead state, the opposite strobe enters `PD_OVERLAP`.
- `PD_OVERLAP` returns to `PD_IDLE` after `OVERLAP` cycles.

A two-bit gain code also selects the pump current, in µA, for the main loop and for the auxiliary loop.

Top module: `pfd_pwr_ctl`

## Requirements
- R1: While reset is held and just after it is released, `pump_up`, `pump_dn` and `div_restart` are all 0.
- R2: In the running state, a reference strobe with no VCO strobe in the same cycle raises `pump_up` after the next clock edge, and `pump_dn` stays 0.
- R3: In the running state, a VCO strobe with no reference strobe in the same cycle raises `pump_dn` after the next clock edge, and `pump_up` stays 0.
- R4: Let the two strobes be d cycles apart, with d at least 1. The leading output is then high for d+OVERLAP cycles and the trailing output for OVERLAP cycles (OVERLAP = 2). Both outputs fall on the same edge.
- R5: Strobes in the same cycle raise both outputs together for exactly OVERLAP cycles.
- R6: When `pwr_on` is high in the off state, `div_restart` is high for exactly one cycle, beginning after the next edge. Strobes sampled while `div_restart` is high start no pulse.
- R7: While powered down, strobes are ignored and both pump outputs stay 0.
- R8: If `pwr_on` falls while a pulse is open, that pulse is not cut short. It ends only after the opposite strobe and the overlap window. No new pulse starts afterwards.
- R9: The main-loop current `rf_ua` is 470, 840, 1410 and 2480 µA for gain codes 00, 01, 10 and 11. Bit 1 of the code selects the high range and bit 0 selects double current.
- R10: The auxiliary-loop current `if_ua` depends only on bit 0 of the gain code: 470 µA when it is 0 and 840 µA when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Power request for the loop |
| ref_stb | input | 1 | One-cycle reference divider strobe |
| vco_stb | input | 1 | One-cycle divided VCO strobe |
| gain_code | input | 2 | Pump gain code: bit 1 selects high range, bit 0 selects double |
| pump_up | output | 1 | Source-current enable |
| pump_dn | output | 1 | Sink-current enable |
| div_restart | output | 1 | One-cycle divider realignment pulse |
| rf_ua | output | CUR_W | Main-loop pump current in µA |
| if_ua | output | CUR_W | Auxiliary-loop pump current in µA |

## Verification
The bench sweeps both arrival orders, coincident strobes and separations from one to nine cycles. A design that miscounts the overlap or lets one output drop early shows up as a wrong pulse width. The bench removes power in the middle of a pulse and checks that the pump stays on until the opposite strobe and the overlap have finished. A sequencer that idles at once would cut that pulse short. The bench also sends a strobe during the restart cycle and while powered down. A design that arms too early, or keeps listening while off, would emit a stray pulse there.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Power sequencer states
    typedef enum logic [1:0] {
        PW_OFF   = 2'd0,
        PW_SYNC  = 2'd1,
        PW_RUN   = 2'd2,
        PW_DRAIN = 2'd3
    } pw_state_t;

    // Detector states; bit 1 drives up, bit 0 drives down
    typedef enum logic [1:0] {
        PD_IDLE    = 2'b00,
        PD_LEAD_DN = 2'b01,
        PD_LEAD_UP = 2'b10,
        PD_OVERLAP = 2'b11
    } pd_state_t;

    localparam int unsigned CUR_BASE_UA  = 470;
    localparam int unsigned CUR_DBL_UA   = 840;
    localparam int unsigned CUR_HI_UA    = 1410;
    localparam int unsigned CUR_HIDBL_UA = 2480;

endpackage

// File: rtl/pfd_gain_map.sv
module pfd_gain_map
    import pfd_pkg::*;
#(
    parameter int CUR_W = 12
) (
    input  logic [1:0]       gain_code,
    output logic [CUR_W-1:0] rf_ua,
    output logic [CUR_W-1:0] if_ua
);

    always_comb begin
        unique case (gain_code)
            2'b00: rf_ua = CUR_W'(CUR_BASE_UA);
            2'b01: rf_ua = CUR_W'(CUR_DBL_UA);
            2'b10: rf_ua = CUR_W'(CUR_HI_UA);
            2'b11: rf_ua = CUR_W'(CUR_HIDBL_UA);
        endcase
        if_ua = gain_code[0] ? CUR_W'(CUR_DBL_UA) : CUR_W'(CUR_BASE_UA);
    end

endmodule

// File: rtl/pfd_power_fsm.sv
module pfd_power_fsm
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic pump_busy,
    output logic start_en,
    output logic div_restart
);

    pw_state_t pw_q, pw_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pw_q <= PW_OFF;
        else        pw_q <= pw_nxt;
    end

    always_comb begin
        pw_nxt = pw_q;
        unique case (pw_q)
            PW_OFF:   if (pwr_on) pw_nxt = PW_SYNC;
            PW_SYNC:  pw_nxt = pwr_on ? PW_RUN : PW_OFF;
            PW_RUN:   if (!pwr_on) pw_nxt = pump_busy ? PW_DRAIN : PW_OFF;
            PW_DRAIN: if (!pump_busy) pw_nxt = PW_OFF;
        endcase
    end

    // Outputs: new pulses only while running with the request still high
    always_comb begin
        start_en    = 1'b0;
        div_restart = 1'b0;
        unique case (pw_q)
            PW_OFF:   ;
            PW_SYNC:  div_restart = 1'b1;
            PW_RUN:   start_en = pwr_on;
            PW_DRAIN: ;
        endcase
    end

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int OVERLAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_en,
    input  logic ref_stb,
    input  logic vco_stb,
    output logic pump_up,
    output logic pump_dn
);

    localparam int OVL_W = (OVERLAP < 2) ? 1 : $clog2(OVERLAP);
    localparam logic [OVL_W-1:0] OVL_LAST = OVL_W'(OVERLAP - 1);

    pd_state_t        pd_q, pd_nxt;
    logic [OVL_W-1:0] ovl_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= PD_IDLE;
        else        pd_q <= pd_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovl_cnt <= '0;
        else if (pd_q == PD_OVERLAP && pd_nxt == PD_OVERLAP)
            ovl_cnt <= ovl_cnt + 1'b1;
        else
            ovl_cnt <= '0;
    end

    // Opening a pulse needs start_en; closing one never does
    always_comb begin
        pd_nxt = pd_q;
        unique case (pd_q)
            PD_IDLE: begin
                if (start_en && ref_stb && vco_stb) pd_nxt = PD_OVERLAP;
                else if (start_en && ref_stb)       pd_nxt = PD_LEAD_UP;
                else if (start_en && vco_stb)       pd_nxt = PD_LEAD_DN;
            end
            PD_LEAD_UP: if (vco_stb) pd_nxt = PD_OVERLAP;
            PD_LEAD_DN: if (ref_stb) pd_nxt = PD_OVERLAP;
            PD_OVERLAP: if (ovl_cnt == OVL_LAST) pd_nxt = PD_IDLE;
        endcase
    end

    // Outputs come straight from state bits, so they cannot glitch
    always_comb begin
        pump_up = pd_q[1];
        pump_dn = pd_q[0];
    end

endmodule

// File: rtl/pfd_pwr_ctl.sv
module pfd_pwr_ctl
    import pfd_pkg::*;
#(
    parameter int OVERLAP = 2,
    parameter int CUR_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             ref_stb,
    input  logic             vco_stb,
    input  logic [1:0]       gain_code,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             div_restart,
    output logic [CUR_W-1:0] rf_ua,
    output logic [CUR_W-1:0] if_ua
);

    logic start_en;
    logic pump_busy;

    assign pump_busy = pump_up | pump_dn;

    pfd_power_fsm u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_on      (pwr_on),
        .pump_busy   (pump_busy),
        .start_en    (start_en),
        .div_restart (div_restart)
    );

    pfd_core #(.OVERLAP(OVERLAP)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_en (start_en),
        .ref_stb  (ref_stb),
        .vco_stb  (vco_stb),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn)
    );

    pfd_gain_map #(.CUR_W(CUR_W)) u_gain (
        .gain_code (gain_code),
        .rf_ua     (rf_ua),
        .if_ua     (if_ua)
    );

endmodule

// File: rtl/pfd_pwr_ctl_chk.sv
module pfd_pwr_ctl_chk #(
    parameter int OVERLAP = 2,
    parameter int CUR_W   = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_on,
    input logic             pump_up,
    input logic             pump_dn,
    input logic             div_restart,
    input logic [CUR_W-1:0] rf_ua,
    input logic [CUR_W-1:0] if_ua
);

    localparam int BC_W = $clog2(OVERLAP + 2);

    logic [BC_W-1:0] both_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            both_cnt <= '0;
        else if (pump_up && pump_dn)
            both_cnt <= (both_cnt == BC_W'(OVERLAP + 1)) ? both_cnt : both_cnt + 1'b1;
        else
            both_cnt <= '0;
    end

    // R4
    overlap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        both_cnt <= BC_W'(OVERLAP));

    // R4
    clear_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |=> (pump_up == pump_dn));

    // R8
    up_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_up) |-> $past(pump_dn));

    // R8
    dn_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_dn) |-> $past(pump_up));

    // R6
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_restart |=> !div_restart);

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_restart |-> (!pump_up && !pump_dn));

    // R7
    up_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pump_up) && !$past(pump_dn)) |-> $past(pwr_on));

    // R7
    dn_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pump_dn) && !$past(pump_up)) |-> $past(pwr_on));

    // R9
    gain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_ua >= if_ua);

endmodule

bind pfd_pwr_ctl pfd_pwr_ctl_chk #(.OVERLAP(OVERLAP), .CUR_W(CUR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_on      (pwr_on),
    .pump_up     (pump_up),
    .pump_dn     (pump_dn),
    .div_restart (div_restart),
    .rf_ua       (rf_ua),
    .if_ua       (if_ua)
);

// File: tb/pfd_pwr_ctl_bench.sv
module pfd_pwr_ctl_bench;

    localparam int OVL = 2;

    // {ref_first[14], sep[13:10], exp_up[9:5], exp_dn[4:0]}
    localparam logic [14:0] PVEC [5] = '{
        {1'b1, 4'd3, 5'd5,  5'd2},
        {1'b0, 4'd3, 5'd2,  5'd5},
        {1'b1, 4'd0, 5'd2,  5'd2},
        {1'b0, 4'd1, 5'd2,  5'd3},
        {1'b1, 4'd9, 5'd11, 5'd2}
    };

    // {code[25:24], rf[23:12], if[11:0]}
    localparam logic [25:0] GVEC [4] = '{
        {2'd0, 12'd470,  12'd470},
        {2'd1, 12'd840,  12'd840},
        {2'd2, 12'd1410, 12'd470},
        {2'd3, 12'd2480, 12'd840}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_on = 1'b0;
    logic        ref_stb = 1'b0;
    logic        vco_stb = 1'b0;
    logic [1:0]  gain_code = 2'd0;
    logic        pump_up, pump_dn, div_restart;
    logic [11:0] rf_ua, if_ua;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pfd_pwr_ctl u_pfd_pwr_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_on      (pwr_on),
        .ref_stb     (ref_stb),
        .vco_stb     (vco_stb),
        .gain_code   (gain_code),
        .pump_up     (pump_up),
        .pump_dn     (pump_dn),
        .div_restart (div_restart),
        .rf_ua       (rf_ua),
        .if_ua       (if_ua)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_pair(input bit ref_first, input int sep,
                            output int nu, output int nd,
                            output int f_up, output int f_dn);
        nu = 0; nd = 0; f_up = 0; f_dn = 0;
        for (int i = 0; i < sep + 8; i++) begin
            ref_stb = ref_first ? (i == 0) : (i == sep);
            vco_stb = ref_first ? (i == sep) : (i == 0);
            @(negedge clk);
            if (i == 0) begin
                f_up = int'(pump_up);
                f_dn = int'(pump_dn);
            end
            nu += int'(pump_up);
            nd += int'(pump_dn);
        end
        ref_stb = 1'b0;
        vco_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nu, nd, fu, fd, rcnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 up in reset", int'(pump_up), 0);
        chk("R1 dn in reset", int'(pump_dn), 0);
        chk("R1 restart in reset", int'(div_restart), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(pump_up | pump_dn | div_restart), 0);

        // R9, R10: gain table
        for (int g = 0; g < 4; g++) begin
            gain_code = GVEC[g][25:24];
            #1;
            chk("R9 rf current", int'(rf_ua), int'(GVEC[g][23:12]));
            chk("R10 if current", int'(if_ua), int'(GVEC[g][11:0]));
        end
        @(negedge clk);

        // R7: strobes while powered down
        run_pair(1'b1, 2, nu, nd, fu, fd);
        chk("R7 off up count", nu, 0);
        chk("R7 off dn count", nd, 0);

        // R6: power-on restart, strobe during restart ignored
        pwr_on = 1'b1;
        @(negedge clk);
        chk("R6 restart high", int'(div_restart), 1);
        ref_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
        chk("R6 restart single cycle", int'(div_restart), 0);
        chk("R6 strobe in restart ignored", int'(pump_up), 0);
        rcnt = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            rcnt += int'(div_restart | pump_up);
        end
        chk("R6 no further restart", rcnt, 0);

        // R2-R5: pulse table
        for (int v = 0; v < 5; v++) begin
            bit rf;
            int sp;
            rf = PVEC[v][14];
            sp = int'(PVEC[v][13:10]);
            run_pair(rf, sp, nu, nd, fu, fd);
            if (sp == 0) begin
                chk("R5 both rise together", fu + fd, 2);
            end else if (rf) begin
                chk("R2 up leads", fu, 1);
                chk("R2 dn quiet at start", fd, 0);
            end else begin
                chk("R3 dn leads", fd, 1);
                chk("R3 up quiet at start", fu, 0);
            end
            chk("R4 up width", nu, int'(PVEC[v][9:5]));
            chk("R4 dn width", nd, int'(PVEC[v][4:0]));
            chk("R4 both low after", int'(pump_up | pump_dn), 0);
        end

        // R8: power removed in the middle of a pulse
        ref_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
        pwr_on = 1'b0;
        chk("R8 pulse opened", int'(pump_up), 1);
        repeat (3) @(negedge clk);
        chk("R8 up held while draining", int'(pump_up), 1);
        chk("R8 dn quiet while draining", int'(pump_dn), 0);
        vco_stb = 1'b1;
        @(negedge clk);
        vco_stb = 1'b0;
        chk("R8 closing overlap", int'(pump_up & pump_dn), 1);
        @(negedge clk);
        chk("R8 overlap second cycle", int'(pump_up & pump_dn), 1);
        @(negedge clk);
        chk("R8 pulse finished", int'(pump_up | pump_dn), 0);
        run_pair(1'b0, 1, nu, nd, fu, fd);
        chk("R8 no new up after off", nu, 0);
        chk("R8 no new dn after off", nd, 0);
        run_pair(1'b1, 0, nu, nd, fu, fd);
        chk("R7 coincident strobes off", nu + nd, 0);

        // R6: second power-on
        pwr_on = 1'b1;
        @(negedge clk);
        chk("R6 restart again", int'(div_restart), 1);
        @(negedge clk);
        chk("R6 restart drops", int'(div_restart), 0);
        run_pair(1'b0, 2, nu, nd, fu, fd);
        chk("R3 armed after restart", nd, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule